// File: doc/BRIEF.md
# Active Video Window Detector

This block locates the active picture inside a raw sync timing stream. It works on one pixel per enabled clock cycle. It takes 8-bit luma together with the horizontal and vertical sync lines, and it learns the polarity of each sync line from its duty cycle. Both sync lines are turned into active-high pulses before any counting is done. From there the block keeps a pixel index within the line and a line index within the frame. It reports the length of each line and the width of the horizontal sync pulse.

Two probes look for picture content:
- **Horizontal probe.** On one chosen line, it records the first and the last pixel that reach the horizontal luma threshold.
- **Vertical probe.** On one chosen column, it records the first and the last line that reach the vertical luma threshold.

The chosen line and column are given in steps of eight. A mode input selects one of two threshold schemes:
- one shared threshold for both probes, or
- a separate threshold for the vertical probe.

Every measured result is copied to the outputs once per frame, at the vertical sync leading edge. Software can therefore read a full, consistent set of results at any time between frames. The suggested settings are:
- both thresholds at 32,
- line select at 6, which is line 48,
- column select at 0x37, which is column 440.

Top module: `video_window_detector`

## Requirements
- R1: Each sync polarity output reads 1 (positive) when, over the previous period, the sync line spent fewer pixel samples high than low; it reads 0 otherwise. The period runs from one raw rising edge to the next. Both outputs read 1 after reset.
- R2: The pixel index is 0 on the sample where the active-high horizontal sync rises, and it counts up by one per enabled sample. `h_total_o` is the number of pixels from one such leading edge to the next.
- R3: `hs_width_o` is the number of enabled samples for which the active-high horizontal sync stayed asserted, counted from its leading edge. It saturates at 255.
- R4: The line index is 0 on the line where the active-high vertical sync rises, and it counts up by one at each horizontal leading edge.
- R5: On line 8 × `h_line_sel_i`, `h_start_o` and `h_end_o` give the first and the last pixel index whose luma passes the horizontal threshold.
- R6: On column 8 × `v_col_sel_i`, `v_start_o` and `v_end_o` give the first and the last line index whose luma passes the vertical threshold.
- R7: A luma value equal to the threshold counts as picture. Any value below the threshold counts as blanking.
- R8: When `sep_thr_i` is 0, the vertical probe uses `h_thr_i` and `v_thr_i` has no effect. When `sep_thr_i` is 1, the vertical probe uses `v_thr_i`.
- R9: If no sample passes on a probe during a frame, that probe reports a start of 2047 (all ones) and an end of 0.
- R10: All position, total and width outputs change only on the sample carrying a vertical leading edge. After reset they read start 2047, end 0, total 0 and width 0.
- R11: Samples with `pix_en_i` low are ignored by every counter and every probe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_en_i | input | 1 | Marks a valid pixel sample |
| hsync_i | input | 1 | Raw horizontal sync, either polarity |
| vsync_i | input | 1 | Raw vertical sync, either polarity |
| luma_i | input | 8 | Pixel brightness |
| sep_thr_i | input | 1 | 1: vertical probe uses its own threshold |
| h_thr_i | input | 8 | Horizontal (and shared) luma threshold |
| v_thr_i | input | 8 | Vertical luma threshold when separated |
| h_line_sel_i | input | 8 | Probe line in units of 8 lines |
| v_col_sel_i | input | 8 | Probe column in units of 8 pixels |
| h_pol_o | output | 1 | Detected horizontal sync polarity, 1 = positive |
| v_pol_o | output | 1 | Detected vertical sync polarity, 1 = positive |
| h_start_o | output | 11 | First picture pixel on the probe line |
| h_end_o | output | 11 | Last picture pixel on the probe line |
| v_start_o | output | 11 | First picture line on the probe column |
| v_end_o | output | 11 | Last picture line on the probe column |
| h_total_o | output | 11 | Pixels per line |
| hs_width_o | output | 8 | Horizontal sync pulse width in pixels |

## Verification
The bench builds the block with its default parameters: 11-bit positions, an 8-bit sync width, and balance counters of 13 and 24 bits. It drives a reduced raster of 80 pixels by 40 lines, so that each scenario runs several whole frames. With this raster, selects of 1 to 4 place the probe line and column inside the picture box, on its edges, or outside it. Short frames also make it cheap to flip both polarities and to thin the enable to every other cycle. Polarity relearning, threshold equality and the empty-probe code are all reached within a few frames per scenario.

// File: rtl/vwd_pkg.sv
package vwd_pkg;
  parameter int unsigned VWD_POS_W = 11;

  typedef struct packed {
    logic                 found;
    logic [VWD_POS_W-1:0] first;
    logic [VWD_POS_W-1:0] last;
  } span_t;

  localparam span_t SPAN_EMPTY = '{found: 1'b0, first: '1, last: '0};
endpackage

// File: rtl/vwd_sync_pol.sv
module vwd_sync_pol #(
  parameter int unsigned CNT_W = 13
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sync_i,
  output logic pol_o,
  output logic act_o,
  output logic lead_o
);
  localparam logic signed [CNT_W-1:0] BAL_MAX = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic signed [CNT_W-1:0] BAL_MIN = {1'b1, {(CNT_W-1){1'b0}}};

  logic                    prev_q, seen_q, pol_q;
  logic signed [CNT_W-1:0] bal_q;
  logic                    raw_rise, prev_act;

  assign raw_rise = en_i & sync_i & ~prev_q;
  // normalize with the current polarity so a polarity flip makes no edge
  assign act_o    = sync_i ^ ~pol_q;
  assign prev_act = prev_q ^ ~pol_q;
  assign lead_o   = en_i & act_o & ~prev_act;
  assign pol_o    = pol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      seen_q <= 1'b0;
      pol_q  <= 1'b1;
      bal_q  <= '0;
    end else if (en_i) begin
      prev_q <= sync_i;
      if (raw_rise) begin
        seen_q <= 1'b1;
        if (seen_q) pol_q <= (bal_q < 0);
        bal_q <= 1;
      end else if (sync_i) begin
        if (bal_q != BAL_MAX) bal_q <= bal_q + 1;
      end else begin
        if (bal_q != BAL_MIN) bal_q <= bal_q - 1;
      end
    end
  end

  p_pol_only_at_edge_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !raw_rise |=> $stable(pol_q));
endmodule

// File: rtl/vwd_timing.sv
module vwd_timing #(
  parameter int unsigned POS_W = 11,
  parameter int unsigned HSW_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             hs_act_i,
  input  logic             hs_lead_i,
  input  logic             vs_lead_i,
  output logic [POS_W-1:0] x_o,
  output logic [POS_W-1:0] y_o,
  output logic [POS_W-1:0] total_o,
  output logic [HSW_W-1:0] width_o
);
  localparam logic [POS_W-1:0] POS_MAX = '1;
  localparam logic [HSW_W-1:0] HSW_MAX = '1;

  logic [POS_W-1:0] x_q, y_q, total_q;
  logic [HSW_W-1:0] width_q;
  logic [POS_W-1:0] x_inc, y_inc;

  assign x_inc = (x_q == POS_MAX) ? POS_MAX : x_q + 1'b1;
  assign y_inc = (y_q == POS_MAX) ? POS_MAX : y_q + 1'b1;

  always_comb begin
    x_o = hs_lead_i ? '0 : x_inc;
    if (vs_lead_i)      y_o = '0;
    else if (hs_lead_i) y_o = y_inc;
    else                y_o = y_q;
  end

  assign total_o = total_q;
  assign width_o = width_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q     <= '0;
      y_q     <= '0;
      total_q <= '0;
      width_q <= '0;
    end else if (en_i) begin
      x_q <= x_o;
      y_q <= y_o;
      if (hs_lead_i) total_q <= x_inc;
      if (hs_lead_i)
        width_q <= HSW_W'(1);
      else if (hs_act_i && width_q != HSW_MAX)
        width_q <= width_q + 1'b1;
    end
  end

  p_x_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !hs_lead_i && x_q != POS_MAX |=> x_q == $past(x_q) + 1'b1);
  p_y_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && (hs_lead_i || vs_lead_i)) |=> $stable(y_q));
  p_width_sat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && hs_act_i && !hs_lead_i && width_q == HSW_MAX |=> width_q == HSW_MAX);
  p_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(x_q) && $stable(total_q) && $stable(width_q));
endmodule

// File: rtl/vwd_span_acc.sv
module vwd_span_acc
  import vwd_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 clear_i,
  input  logic                 hit_i,
  input  logic [VWD_POS_W-1:0] pos_i,
  output span_t                span_o
);
  span_t span_q, base, span_d;

  always_comb begin
    base   = clear_i ? SPAN_EMPTY : span_q;
    span_d = base;
    if (hit_i) begin
      if (!base.found) span_d.first = pos_i;
      span_d.last  = pos_i;
      span_d.found = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   span_q <= SPAN_EMPTY;
    else if (en_i) span_q <= span_d;
  end

  assign span_o = span_q;

  p_span_order_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    span_q.found |-> span_q.first <= span_q.last);
  p_span_first_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !clear_i && span_q.found |=> span_q.first == $past(span_q.first));
endmodule

// File: rtl/video_window_detector.sv
module video_window_detector
  import vwd_pkg::*;
#(
  parameter int unsigned LUMA_W    = 8,
  parameter int unsigned SEL_W     = 8,
  parameter int unsigned SEL_SHIFT = 3,
  parameter int unsigned HSW_W     = 8,
  parameter int unsigned HCNT_W    = 13,
  parameter int unsigned VCNT_W    = 24
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pix_en_i,
  input  logic                 hsync_i,
  input  logic                 vsync_i,
  input  logic [LUMA_W-1:0]    luma_i,
  input  logic                 sep_thr_i,
  input  logic [LUMA_W-1:0]    h_thr_i,
  input  logic [LUMA_W-1:0]    v_thr_i,
  input  logic [SEL_W-1:0]     h_line_sel_i,
  input  logic [SEL_W-1:0]     v_col_sel_i,
  output logic                 h_pol_o,
  output logic                 v_pol_o,
  output logic [VWD_POS_W-1:0] h_start_o,
  output logic [VWD_POS_W-1:0] h_end_o,
  output logic [VWD_POS_W-1:0] v_start_o,
  output logic [VWD_POS_W-1:0] v_end_o,
  output logic [VWD_POS_W-1:0] h_total_o,
  output logic [HSW_W-1:0]     hs_width_o
);
  localparam int unsigned POS_W = VWD_POS_W;
  localparam int unsigned NSYNC = 2;

  logic [NSYNC-1:0] sync_raw, pol, act, lead;
  assign sync_raw = {vsync_i, hsync_i};

  for (genvar g = 0; g < NSYNC; g++) begin : g_sync
    localparam int unsigned CW = (g == 0) ? HCNT_W : VCNT_W;
    vwd_sync_pol #(.CNT_W(CW)) u_pol (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (pix_en_i),
      .sync_i (sync_raw[g]),
      .pol_o  (pol[g]),
      .act_o  (act[g]),
      .lead_o (lead[g])
    );
  end

  assign h_pol_o = pol[0];
  assign v_pol_o = pol[1];

  logic [POS_W-1:0] cur_x, cur_y, total_live;
  logic [HSW_W-1:0] width_live;

  vwd_timing #(.POS_W(POS_W), .HSW_W(HSW_W)) u_timing (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (pix_en_i),
    .hs_act_i  (act[0]),
    .hs_lead_i (lead[0]),
    .vs_lead_i (lead[1]),
    .x_o       (cur_x),
    .y_o       (cur_y),
    .total_o   (total_live),
    .width_o   (width_live)
  );

  logic [POS_W-1:0]  line_tgt, col_tgt;
  logic [LUMA_W-1:0] v_thr_eff;
  logic [1:0]        hit;
  logic [1:0][POS_W-1:0] probe_pos;
  span_t             span [2];

  assign line_tgt     = POS_W'({h_line_sel_i, {SEL_SHIFT{1'b0}}});
  assign col_tgt      = POS_W'({v_col_sel_i, {SEL_SHIFT{1'b0}}});
  assign v_thr_eff    = sep_thr_i ? v_thr_i : h_thr_i;
  assign hit[0]       = pix_en_i && (cur_y == line_tgt) && (luma_i >= h_thr_i);
  assign hit[1]       = pix_en_i && (cur_x == col_tgt) && (luma_i >= v_thr_eff);
  assign probe_pos[0] = cur_x;
  assign probe_pos[1] = cur_y;

  for (genvar g = 0; g < 2; g++) begin : g_probe
    vwd_span_acc u_acc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (pix_en_i),
      .clear_i (lead[1]),
      .hit_i   (hit[g]),
      .pos_i   (probe_pos[g]),
      .span_o  (span[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_start_o  <= '1;
      h_end_o    <= '0;
      v_start_o  <= '1;
      v_end_o    <= '0;
      h_total_o  <= '0;
      hs_width_o <= '0;
    end else if (lead[1]) begin
      h_start_o  <= span[0].found ? span[0].first : '1;
      h_end_o    <= span[0].found ? span[0].last  : '0;
      v_start_o  <= span[1].found ? span[1].first : '1;
      v_end_o    <= span[1].found ? span[1].last  : '0;
      h_total_o  <= total_live;
      hs_width_o <= width_live;
    end
  end

  p_latch_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lead[1] |=> $stable(h_start_o) && $stable(v_end_o) && $stable(h_total_o)
                 && $stable(hs_width_o));
  p_empty_code_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_start_o > h_end_o |-> (h_start_o == '1) && (h_end_o == '0));
  p_empty_code_v_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_start_o > v_end_o |-> (v_start_o == '1) && (v_end_o == '0));
endmodule

// File: tb/video_window_detector_test.sv
module video_window_detector_test;
  localparam int HTOT = 80;
  localparam int VTOT = 40;
  localparam int VSW  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_en = 1'b0, hsync = 1'b0, vsync = 1'b0, sep_thr = 1'b0;
  logic [7:0] luma = '0, h_thr = 8'd32, v_thr = 8'd32, h_sel = 8'd2, v_sel = 8'd5;
  logic h_pol, v_pol;
  logic [10:0] h_start, h_end, v_start, v_end, h_total;
  logic [7:0] hs_width;

  int errors = 0, checks = 0;
  int hp = 1, vp = 1, hsw = 6, gap = 0;
  int bx0 = 20, bx1 = 60, by0 = 10, by1 = 30, in_val = 32, out_val = 31;

  always #4 clk = ~clk;

  video_window_detector uut (
    .clk_i(clk), .rst_ni(rst_n), .pix_en_i(pix_en), .hsync_i(hsync), .vsync_i(vsync),
    .luma_i(luma), .sep_thr_i(sep_thr), .h_thr_i(h_thr), .v_thr_i(v_thr),
    .h_line_sel_i(h_sel), .v_col_sel_i(v_col_sel_w()), .h_pol_o(h_pol), .v_pol_o(v_pol),
    .h_start_o(h_start), .h_end_o(h_end), .v_start_o(v_start), .v_end_o(v_end),
    .h_total_o(h_total), .hs_width_o(hs_width)
  );

  function automatic logic [7:0] v_col_sel_w();
    return v_sel;
  endfunction

  function automatic int luma_at(int x, int y);
    return (x >= bx0 && x <= bx1 && y >= by0 && y <= by1) ? in_val : out_val;
  endfunction

  task automatic chk(string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  task automatic put_pix(int x, int y);
    @(negedge clk);
    pix_en = 1'b1;
    hsync  = (x < hsw) ? hp[0] : ~hp[0];
    vsync  = (y < VSW) ? vp[0] : ~vp[0];
    luma   = 8'(luma_at(x, y));
    if (gap != 0) begin
      @(negedge clk);
      pix_en = 1'b0;
      luma   = 8'hFF;
    end
  endtask

  task automatic run_frames(int nf);
    for (int f = 0; f < nf; f++)
      for (int y = 0; y < VTOT; y++)
        for (int x = 0; x < HTOT; x++) put_pix(x, y);
    put_pix(0, 0);
    @(negedge clk);
    pix_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic check_results(string tag);
    int hs = 2047, he = 0, vs = 2047, ve = 0;
    int vt = sep_thr ? int'(v_thr) : int'(h_thr);
    for (int x = 0; x < HTOT; x++)
      if (luma_at(x, h_sel * 8) >= h_thr) begin
        if (hs == 2047) hs = x;
        he = x;
      end
    for (int y = 0; y < VTOT; y++)
      if (luma_at(v_sel * 8, y) >= vt) begin
        if (vs == 2047) vs = y;
        ve = y;
      end
    chk({tag, " R1 h_pol"}, h_pol, hp);
    chk({tag, " R1 v_pol"}, v_pol, vp);
    chk({tag, " R2 h_total"}, h_total, HTOT);
    chk({tag, " R3 hs_width"}, hs_width, hsw);
    chk({tag, " R5 R7 h_start"}, h_start, hs);
    chk({tag, " R5 R7 h_end"}, h_end, he);
    chk({tag, " R4 R6 R8 v_start"}, v_start, vs);
    chk({tag, " R4 R6 R8 v_end"}, v_end, ve);
  endtask

  task automatic t_reset();
    chk("R10 reset h_start", h_start, 2047);
    chk("R10 reset h_end", h_end, 0);
    chk("R9 reset v_start", v_start, 2047);
    chk("R10 reset h_total", h_total, 0);
    chk("R10 reset hs_width", hs_width, 0);
    chk("R1 reset h_pol", h_pol, 1);
    chk("R1 reset v_pol", v_pol, 1);
  endtask

  // shared threshold, v_thr set high must be ignored (R8), edge value 32 passes (R7)
  task automatic t_basic();
    hp = 1; vp = 1; hsw = 6; gap = 0; sep_thr = 1'b0;
    h_thr = 8'd32; v_thr = 8'd200; h_sel = 8'd2; v_sel = 8'd5;
    bx0 = 20; bx1 = 60; by0 = 10; by1 = 30; in_val = 32; out_val = 31;
    run_frames(4);
    check_results("basic");
  endtask

  // negative syncs, enable on every other cycle (R11)
  task automatic t_neg_gap();
    hp = 0; vp = 0; hsw = 12; gap = 1;
    h_sel = 8'd3; v_sel = 8'd1;
    bx0 = 8; bx1 = 70; by0 = 5; by1 = 35; in_val = 200; out_val = 0;
    run_frames(4);
    check_results("neg_gap R11");
    gap = 0;
  endtask

  task automatic t_split();
    hp = 1; vp = 1; hsw = 6; sep_thr = 1'b1;
    h_thr = 8'd32; v_thr = 8'd100; h_sel = 8'd2; v_sel = 8'd5;
    bx0 = 20; bx1 = 60; by0 = 10; by1 = 30; in_val = 50; out_val = 0;
    run_frames(4);
    check_results("split R8");
    chk("R9 empty v_start", v_start, 2047);
    chk("R9 empty v_end", v_end, 0);
    v_thr = 8'd50;
    run_frames(4);
    check_results("split_eq R7 R8");
    sep_thr = 1'b0;
  endtask

  task automatic t_miss_line();
    h_sel = 8'd4;
    run_frames(4);
    check_results("miss R9");
    chk("R9 empty h_start", h_start, 2047);
    chk("R9 empty h_end", h_end, 0);
  endtask

  // outputs must not move before the next vertical leading edge
  task automatic t_hold();
    h_sel = 8'd2;
    for (int y = 0; y < 20; y++)
      for (int x = 0; x < HTOT; x++) put_pix(x, y);
    @(negedge clk);
    pix_en = 1'b0;
    repeat (30) begin
      @(negedge clk);
      hsync = ~hsync;
      vsync = ~vsync;
      luma  = 8'hFF;
    end
    chk("R10 hold h_start", h_start, 2047);
    chk("R10 hold h_end", h_end, 0);
    chk("R10 hold h_total", h_total, HTOT);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_basic();
    t_neg_gap();
    t_split();
    t_miss_line();
    t_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule